// File: doc/BRIEF.md
# Debounced Push-Button Command Unit

This block turns five raw, asynchronous push-button levels into clean commands for the logic on a board. Each key is first brought into the clock domain by a two-stage synchronizer. A counter-based filter then sets a debounced level, and a rising-edge detector turns that level into a single clock-wide pulse. One physical press therefore yields one pulse, however long the key is held and however much its contacts chatter.

Four keys give pulse commands. Left loads operand A, right loads operand B, up requests a single step, and down requests the next output. The centre key does not give a pulse. Its edge sets a run flag, which stays high until the synchronous active-low reset clears it. The filter window is a parameter. Its default, 2^20 cycles, is about 10 ms at 100 MHz.

Top module: `btn_cmd_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four command pulses and `run_active` are low after that edge, and the filter state of every key is cleared.
- R2: A key held high for any length of time produces exactly one command pulse, one clock cycle wide. Releasing the key produces no pulse.
- R3: The mapping is fixed: `key_left` drives `cmd_load_a`, `key_right` drives `cmd_load_b`, `key_up` drives `cmd_step`, and `key_down` drives `cmd_next`.
- R4: The debounced level of a key changes only after its synchronized input has differed from it for `DEBOUNCE_CYCLES` consecutive cycles. Any cycle in which the input agrees with the level again restarts the count from zero.
- R5: A high glitch or chatter burst whose high runs are each shorter than `DEBOUNCE_CYCLES` cycles produces no pulse and does not set `run_active`.
- R6: A debounced press of `key_center` sets `run_active` one cycle after its internal edge. Once set, the flag stays high through further presses and releases until reset.
- R7: A key that rises before clock edge E and stays high gives a pulse in the cycle that follows edge E+`DEBOUNCE_CYCLES`+1. That is two synchronizer stages plus the filter window.
- R8: The keys are independent. Keys pressed together give their pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_left | input | 1 | Raw left key, asynchronous, high when pressed |
| key_right | input | 1 | Raw right key |
| key_up | input | 1 | Raw up key |
| key_down | input | 1 | Raw down key |
| key_center | input | 1 | Raw centre key |
| cmd_load_a | output | 1 | One-cycle pulse: load operand A |
| cmd_load_b | output | 1 | One-cycle pulse: load operand B |
| cmd_step | output | 1 | One-cycle pulse: single step |
| cmd_next | output | 1 | One-cycle pulse: next output |
| run_active | output | 1 | Sticky run flag, cleared only by reset |

## Verification
The hardest case to reach from the ports is a filter count that climbs to one short of the window and is then reset by a single agreeing sample. Only that restart separates a correct filter from one that merely accumulates mismatches. The bench builds this with chatter bursts whose high runs last exactly one cycle fewer than the window, separated by single low cycles. It then gives a high run of exactly the window length and checks the pulse latency to the cycle. A reset asserted after the run flag has been set, followed by a one-cycle centre glitch, shows both the clearing and the glitch rejection on the flag.

// File: rtl/btn_cmd_pkg.sv
// Package: shared key indices and counts for the button command unit.
// Assumes keys are packed into a vector in the order given by key_idx_e.
package btn_cmd_pkg;

    localparam int NUM_KEYS = 5;
    localparam int NUM_CMDS = 4;

    typedef enum int {
        KEY_LEFT   = 0,
        KEY_RIGHT  = 1,
        KEY_UP     = 2,
        KEY_DOWN   = 3,
        KEY_CENTER = 4
    } key_idx_e;

endpackage

// File: rtl/btn_sync.sv
// Module: btn_sync
// Brings one asynchronous level into the clock domain through a chain of
// STAGES flip-flops. Assumes STAGES >= 2 and a synchronous active-low reset.
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/btn_debounce.sv
// Module: btn_debounce
// Filters a synchronized level. The output level changes only after the
// input has disagreed with it for WINDOW consecutive cycles; any agreeing
// cycle restarts the count. Assumes WINDOW >= 1.
module btn_debounce #(
    parameter int WINDOW = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);

    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             level_q;

    // Count consecutive disagreeing cycles and flip the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (level_in != level_q) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q   <= '0;
                level_q <= level_in;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign level_out = level_q;

endmodule

// File: rtl/btn_edge.sv
// Module: btn_edge
// Gives a one-cycle pulse in the cycle after a clean level rises.
// Assumes the input is already debounced and synchronous.
module btn_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;

endmodule

// File: rtl/btn_cmd_unit.sv
// Module: btn_cmd_unit
// Five raw keys -> synchronizer -> debouncer -> rising-edge pulse.
// Four pulses leave as commands; the centre pulse sets a sticky run flag.
// Assumes one clock and a synchronous active-low reset for every stage.
module btn_cmd_unit
    import btn_cmd_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 1 << 20,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_left,
    input  logic key_right,
    input  logic key_up,
    input  logic key_down,
    input  logic key_center,
    output logic cmd_load_a,
    output logic cmd_load_b,
    output logic cmd_step,
    output logic cmd_next,
    output logic run_active
);

    logic [NUM_KEYS-1:0] raw_key;
    logic [NUM_KEYS-1:0] sync_key;
    logic [NUM_KEYS-1:0] deb_level;
    logic [NUM_KEYS-1:0] key_pulse;
    logic                run_q;

    assign raw_key[KEY_LEFT]   = key_left;
    assign raw_key[KEY_RIGHT]  = key_right;
    assign raw_key[KEY_UP]     = key_up;
    assign raw_key[KEY_DOWN]   = key_down;
    assign raw_key[KEY_CENTER] = key_center;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_key[k]),
            .sync_out (sync_key[k])
        );

        btn_debounce #(.WINDOW(DEBOUNCE_CYCLES)) u_deb (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_in  (sync_key[k]),
            .level_out (deb_level[k])
        );

        btn_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .level (deb_level[k]),
            .rise  (key_pulse[k])
        );
    end

    // Run latch: the register loads a constant one when the centre pulse enables it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   run_q <= 1'b0;
        else if (key_pulse[KEY_CENTER]) run_q <= 1'b1;
    end

    assign cmd_load_a = key_pulse[KEY_LEFT];
    assign cmd_load_b = key_pulse[KEY_RIGHT];
    assign cmd_step   = key_pulse[KEY_UP];
    assign cmd_next   = key_pulse[KEY_DOWN];
    assign run_active = run_q;

endmodule

// File: rtl/btn_cmd_checks.sv
// Module: btn_cmd_checks
// Property checks for btn_cmd_unit, attached with bind below.
module btn_cmd_checks #(
    parameter int NKEYS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cmds,
    input logic             run_active,
    input logic             center_pulse,
    input logic [NKEYS-1:0] level,
    input logic [NKEYS-1:0] synced
);

    // R1: reset clears every output at the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cmds == 4'b0) && !run_active);

    // R2: no command pulse lasts two cycles.
    for (genvar c = 0; c < 4; c++) begin : g_cmd
        a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            cmds[c] |=> !cmds[c]);
    end

    // R4: a debounced level moves only towards the synchronized input.
    for (genvar k = 0; k < NKEYS; k++) begin : g_lvl
        a_r4_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
            (level[k] != $past(level[k])) |-> ($past(synced[k]) == level[k]));
    end

    // R6: the run flag never drops outside reset.
    a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_active |=> run_active);

    // R6: the run flag rises only after a centre edge.
    a_r6_run_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_active) |-> $past(center_pulse));

endmodule

bind btn_cmd_unit btn_cmd_checks #(.NKEYS(btn_cmd_pkg::NUM_KEYS)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmds         ({cmd_next, cmd_step, cmd_load_b, cmd_load_a}),
    .run_active   (run_active),
    .center_pulse (key_pulse[btn_cmd_pkg::KEY_CENTER]),
    .level        (deb_level),
    .synced       (sync_key)
);

// File: tb/btn_cmd_unit_bench.sv
// Bench for btn_cmd_unit: a behavioural model that runs in step with the
// design and is compared on every clock, plus directed checks.
module btn_cmd_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] keys = '0;   // [0]left [1]right [2]up [3]down [4]center
    logic cmd_load_a, cmd_load_b, cmd_step, cmd_next, run_active;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int pcount[4];
    int plast[4];

    // Model state
    int m_pipe[5][$];
    int m_cnt[5];
    int m_lvl[5];
    int m_prv[5];
    int m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_cmd_unit #(.DEBOUNCE_CYCLES(WIN)) u_btn_cmd_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_left   (keys[0]),
        .key_right  (keys[1]),
        .key_up     (keys[2]),
        .key_down   (keys[3]),
        .key_center (keys[4]),
        .cmd_load_a (cmd_load_a),
        .cmd_load_b (cmd_load_b),
        .cmd_step   (cmd_step),
        .cmd_next   (cmd_next),
        .run_active (run_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Model: advance one clock with the key levels seen at this edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) begin
                m_pipe[k] = '{0, 0};
                m_cnt[k] = 0; m_lvl[k] = 0; m_prv[k] = 0;
            end
            m_run = 0;
        end else begin
            if (m_lvl[4] == 1 && m_prv[4] == 0) m_run = 1;
            for (int k = 0; k < 5; k++) begin
                int seen;
                seen = m_pipe[k][0];
                m_prv[k] = m_lvl[k];
                if (seen != m_lvl[k]) begin
                    m_cnt[k]++;
                    if (m_cnt[k] >= WIN) begin m_lvl[k] = seen; m_cnt[k] = 0; end
                end else begin
                    m_cnt[k] = 0;
                end
                void'(m_pipe[k].pop_front());
                m_pipe[k].push_back(int'(keys[k]));
            end
        end
    end

    // Compare every cycle and tally pulses, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            logic [3:0] got;
            got = {cmd_next, cmd_step, cmd_load_b, cmd_load_a};
            for (int k = 0; k < 4; k++) begin
                int e;
                e = (m_lvl[k] == 1 && m_prv[k] == 0) ? 1 : 0;
                check(int'(got[k]) == e, $sformatf("R3 cmd %0d per-cycle", k), int'(got[k]), e);
                if (got[k]) begin pcount[k]++; plast[k] = cyc; end
            end
            check(int'(run_active) == m_run, "R6 run per-cycle", int'(run_active), m_run);
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic clear_counts();
        for (int k = 0; k < 4; k++) begin pcount[k] = 0; plast[k] = -1; end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [4:0] m, input int hold);
        @(negedge clk); keys = keys | m;
        idle(hold);
        keys = keys & ~m;
        idle(WIN + 6);
    endtask

    initial begin
        clear_counts();
        idle(4);
        // R1: reset state
        check(cmd_load_a == 0 && cmd_load_b == 0 && cmd_step == 0 && cmd_next == 0,
              "R1 pulses in reset", int'({cmd_next, cmd_step, cmd_load_b, cmd_load_a}), 0);
        check(run_active == 0, "R1 run in reset", int'(run_active), 0);
        rst_n = 1'b1;
        idle(2);

        // R2/R3: each key alone gives one pulse on its own output
        for (int k = 0; k < 4; k++) begin
            clear_counts();
            press(5'b1 << k, 20);
            for (int j = 0; j < 4; j++)
                check(pcount[j] == ((j == k) ? 1 : 0), "R3 key mapping", pcount[j], (j == k) ? 1 : 0);
        end

        // R2: long hold, chattering release
        clear_counts();
        @(negedge clk); keys[0] = 1'b1;
        idle(100);
        for (int r = 0; r < 4; r++) begin keys[0] = 1'b0; idle(WIN - 1); keys[0] = 1'b1; idle(1); end
        keys[0] = 1'b0;
        idle(WIN + 6);
        check(pcount[0] == 1, "R2 one pulse per held press", pcount[0], 1);

        // R7: latency from edge to pulse
        clear_counts();
        @(negedge clk); keys[2] = 1'b1;
        begin
            int waited = 0;
            while (!cmd_step && waited < 40) begin @(negedge clk); waited++; end
            check(waited == WIN + 2, "R7 press latency", waited, WIN + 2);
        end
        idle(5); keys[2] = 1'b0; idle(WIN + 6);

        // R4/R5: chatter with high runs one short of the window
        clear_counts();
        for (int r = 0; r < 6; r++) begin
            @(negedge clk); keys[1] = 1'b1; idle(WIN - 1); keys[1] = 1'b0;
        end
        idle(WIN + 6);
        check(pcount[1] == 0, "R5 chatter rejected", pcount[1], 0);
        // R4: exactly the window length is accepted
        @(negedge clk); keys[1] = 1'b1; idle(WIN); keys[1] = 1'b0;
        idle(WIN + 6);
        check(pcount[1] == 1, "R4 full window accepted", pcount[1], 1);

        // R8: simultaneous presses
        clear_counts();
        press(5'b01001, 15);
        check(pcount[0] == 1 && pcount[3] == 1, "R8 both pulsed", pcount[0] + pcount[3], 2);
        check(plast[0] == plast[3], "R8 same cycle", plast[0], plast[3]);

        // R6: run flag
        check(run_active == 0, "R6 run low before centre", int'(run_active), 0);
        press(5'b10000, 12);
        check(run_active == 1, "R6 run set", int'(run_active), 1);
        press(5'b10000, 12);
        idle(20);
        check(run_active == 1, "R6 run stays", int'(run_active), 1);

        // R1: reset clears run; R5: a one-cycle centre glitch does not set it
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check(run_active == 0, "R1 run cleared by reset", int'(run_active), 0);
        rst_n = 1'b1;
        idle(2);
        press(5'b10000, 1);
        check(run_active == 0, "R5 glitch leaves run low", int'(run_active), 0);

        idle(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule